// File: doc/BRIEF.md
# Paired Byte Register File

This block holds the general-purpose registers of a small 8-bit processor. It is a bank of eight byte-wide registers, and each one is picked by a 3-bit address. The registers also form four 16-bit pairs. An even address holds the low byte of a pair and the next odd address holds the high byte. Two independent byte read ports serve the ALU operands and the data path. A single byte write port stores results.

A 16-bit result goes into a pair through two byte writes on successive cycles: low byte to the even address, high byte to the odd one. Address generation reads a whole pair at once through a combined 16-bit read port. That port ignores bit 0 of its address. All reads are combinational. A write takes effect on the rising clock edge. An asynchronous active-low reset clears every register to zero.

Top module: `regfile_paired`

## Requirements
- R1: While rst_ni is low, every register reads as zero on both byte ports and the pair port.
- R2: Reset is asynchronous. Driving rst_ni low clears the registers with no clock edge needed.
- R3: When wr_en_i is high at a rising clock edge, wr_data_i is stored in the register at wr_addr_i, and no other register changes.
- R4: When wr_en_i is low at a rising edge, no register changes.
- R5: rd_a_data_o combinationally shows the register addressed by rd_a_addr_i.
- R6: rd_b_data_o combinationally shows the register addressed by rd_b_addr_i, independent of port A.
- R7: If a read and a write to the same address happen in the same cycle, the read returns the old value until the clock edge, and the new value after it.
- R8: The register encoding is AL=0, AH=1, BL=2, BH=3, CL=4, CH=5, DL=6, DH=7. pair_data_o is {register at pair_addr_i with bit 0 set to 1, register at pair_addr_i with bit 0 cleared to 0}, so the high byte is in bits 15:8. Bit 0 of pair_addr_i has no effect on the result.
- R9: A 16-bit value stored as two byte writes (low byte to the even address, then high byte to the odd address) reads back whole on pair_data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write enable |
| wr_addr_i | input | 3 | Byte write address |
| wr_data_i | input | 8 | Byte write data |
| rd_a_addr_i | input | 3 | Read port A address |
| rd_a_data_o | output | 8 | Read port A data |
| rd_b_addr_i | input | 3 | Read port B address |
| rd_b_data_o | output | 8 | Read port B data |
| pair_addr_i | input | 3 | Pair read address, bit 0 ignored |
| pair_data_o | output | 16 | Pair read data, high byte in upper half |

## Verification
Read results depend only on the addresses and the stored state, so they are due in the same cycle: the bench changes an address and samples 1 ns later. A write is due one edge after it is presented. The bench drives inputs on the falling edge and samples shortly after the next rising edge. The same-address test samples both before and after that edge to see the old value, then the new one. Reset is checked mid-cycle, with no edge in between, to show that it acts without a clock.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam int unsigned PAIRS_DEF  = 4;

  typedef enum logic [2:0] {
    REG_AL = 3'd0, REG_AH = 3'd1,
    REG_BL = 3'd2, REG_BH = 3'd3,
    REG_CL = 3'd4, REG_CH = 3'd5,
    REG_DL = 3'd6, REG_DH = 3'd7
  } reg_name_e;
endpackage

// File: rtl/regfile_byte_bank.sv
module regfile_byte_bank #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned N_REGS = 8,
  localparam int unsigned ADDR_W = $clog2(N_REGS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [BYTE_W-1:0]             wr_data_i,
  output logic [N_REGS-1:0][BYTE_W-1:0] regs_o
);
  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_o[i] <= '0;
      else if (hit) regs_o[i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/regfile_rd_mux.sv
module regfile_rd_mux #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned N_REGS = 8,
  localparam int unsigned ADDR_W = $clog2(N_REGS)
) (
  input  logic [N_REGS-1:0][BYTE_W-1:0] regs_i,
  input  logic [ADDR_W-1:0]             addr_i,
  output logic [BYTE_W-1:0]             data_o
);
  assign data_o = regs_i[addr_i];
endmodule

// File: rtl/regfile_pair_rd.sv
module regfile_pair_rd #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned N_REGS = 8,
  localparam int unsigned ADDR_W = $clog2(N_REGS)
) (
  input  logic [N_REGS-1:0][BYTE_W-1:0] regs_i,
  input  logic [ADDR_W-1:0]             addr_i,
  output logic [2*BYTE_W-1:0]           data_o
);
  logic [ADDR_W-1:0] lo_idx, hi_idx;
  // force bit 0: even index is the low byte, odd the high byte
  assign lo_idx = addr_i & ~ADDR_W'(1);
  assign hi_idx = lo_idx | ADDR_W'(1);
  assign data_o = {regs_i[hi_idx], regs_i[lo_idx]};
endmodule

// File: rtl/regfile_paired.sv
module regfile_paired
  import regfile_pkg::*;
#(
  parameter int unsigned BYTE_W  = BYTE_W_DEF,
  parameter int unsigned N_PAIRS = PAIRS_DEF,
  localparam int unsigned N_REGS = 2 * N_PAIRS,
  localparam int unsigned ADDR_W = $clog2(N_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [BYTE_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   rd_a_addr_i,
  output logic [BYTE_W-1:0]   rd_a_data_o,
  input  logic [ADDR_W-1:0]   rd_b_addr_i,
  output logic [BYTE_W-1:0]   rd_b_data_o,
  input  logic [ADDR_W-1:0]   pair_addr_i,
  output logic [2*BYTE_W-1:0] pair_data_o
);
  logic [N_REGS-1:0][BYTE_W-1:0] regs;

  regfile_byte_bank #(.BYTE_W(BYTE_W), .N_REGS(N_REGS)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .regs_o    (regs)
  );

  regfile_rd_mux #(.BYTE_W(BYTE_W), .N_REGS(N_REGS)) u_rd_a (
    .regs_i (regs),
    .addr_i (rd_a_addr_i),
    .data_o (rd_a_data_o)
  );

  regfile_rd_mux #(.BYTE_W(BYTE_W), .N_REGS(N_REGS)) u_rd_b (
    .regs_i (regs),
    .addr_i (rd_b_addr_i),
    .data_o (rd_b_data_o)
  );

  regfile_pair_rd #(.BYTE_W(BYTE_W), .N_REGS(N_REGS)) u_pair (
    .regs_i (regs),
    .addr_i (pair_addr_i),
    .data_o (pair_data_o)
  );
endmodule

// File: rtl/regfile_paired_chk.sv
module regfile_paired_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   wr_addr_i,
  input logic [BYTE_W-1:0]   wr_data_i,
  input logic [ADDR_W-1:0]   rd_a_addr_i,
  input logic [BYTE_W-1:0]   rd_a_data_o,
  input logic [ADDR_W-1:0]   rd_b_addr_i,
  input logic [BYTE_W-1:0]   rd_b_data_o,
  input logic [ADDR_W-1:0]   pair_addr_i,
  input logic [2*BYTE_W-1:0] pair_data_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (rd_a_data_o == '0 && rd_b_data_o == '0 && pair_data_o == '0));

  assert_write_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(wr_en_i) && rd_a_addr_i == $past(wr_addr_i)
    |-> rd_a_data_o == $past(wr_data_i));

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$past(wr_en_i) && $stable(rd_b_addr_i) |-> $stable(rd_b_data_o));

  assert_ports_agree_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_addr_i == rd_b_addr_i |-> rd_a_data_o == rd_b_data_o);

  assert_pair_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_addr_i | ADDR_W'(1)) == (rd_a_addr_i | ADDR_W'(1)) && !rd_a_addr_i[0]
    |-> pair_data_o[BYTE_W-1:0] == rd_a_data_o);

  assert_pair_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_addr_i | ADDR_W'(1)) == rd_b_addr_i
    |-> pair_data_o[2*BYTE_W-1:BYTE_W] == rd_b_data_o);
endmodule

bind regfile_paired regfile_paired_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .rd_a_addr_i (rd_a_addr_i),
  .rd_a_data_o (rd_a_data_o),
  .rd_b_addr_i (rd_b_addr_i),
  .rd_b_data_o (rd_b_data_o),
  .pair_addr_i (pair_addr_i),
  .pair_data_o (pair_data_o)
);

// File: tb/tb_regfile_paired.sv
`timescale 1ns/1ps
module tb_regfile_paired;
  import regfile_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [2:0]  rd_a_addr_i = '0;
  logic [7:0]  rd_a_data_o;
  logic [2:0]  rd_b_addr_i = '0;
  logic [7:0]  rd_b_data_o;
  logic [2:0]  pair_addr_i = '0;
  logic [15:0] pair_data_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] model [8];

  always #5 clk_i = ~clk_i;

  regfile_paired dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_a_addr_i(rd_a_addr_i), .rd_a_data_o(rd_a_data_o),
    .rd_b_addr_i(rd_b_addr_i), .rd_b_data_o(rd_b_data_o),
    .pair_addr_i(pair_addr_i), .pair_data_o(pair_data_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // present a byte write at the falling edge, commit at the next rising edge
  task automatic wr_byte(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); #1;
    model[a] = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset_state();
    #1;
    for (int i = 0; i < 8; i++) begin
      rd_a_addr_i = 3'(i); rd_b_addr_i = 3'(7 - i); pair_addr_i = 3'(i); #1;
      chk("R1 port A", {8'h0, rd_a_data_o}, 16'h0);
      chk("R1 port B", {8'h0, rd_b_data_o}, 16'h0);
      chk("R1 pair", pair_data_o, 16'h0);
    end
  endtask

  task automatic t_write_all();
    for (int i = 0; i < 8; i++) wr_byte(3'(i), 8'(8'h31 + 8'(i) * 8'h17));
    for (int i = 0; i < 8; i++) begin
      rd_a_addr_i = 3'(i); rd_b_addr_i = 3'(7 - i); #1;
      chk("R3/R5 port A", {8'h0, rd_a_data_o}, {8'h0, model[i]});
      chk("R6 port B", {8'h0, rd_b_data_o}, {8'h0, model[7 - i]});
    end
  endtask

  task automatic t_isolation();
    wr_byte(REG_CH, 8'hA5);
    for (int i = 0; i < 8; i++) begin
      rd_a_addr_i = 3'(i); #1;
      chk("R3 only target changes", {8'h0, rd_a_data_o}, {8'h0, model[i]});
    end
  endtask

  task automatic t_we_low();
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_addr_i = REG_BL; wr_data_i = 8'hEE;
    @(posedge clk_i); @(posedge clk_i); #1;
    for (int i = 0; i < 8; i++) begin
      rd_b_addr_i = 3'(i); #1;
      chk("R4 disabled write", {8'h0, rd_b_data_o}, {8'h0, model[i]});
    end
  endtask

  task automatic t_same_cycle();
    @(negedge clk_i);
    rd_a_addr_i = REG_DL; rd_b_addr_i = REG_DL;
    wr_en_i = 1'b1; wr_addr_i = REG_DL; wr_data_i = 8'h5C; #1;
    chk("R7 old value before edge A", {8'h0, rd_a_data_o}, {8'h0, model[REG_DL]});
    chk("R7 old value before edge B", {8'h0, rd_b_data_o}, {8'h0, model[REG_DL]});
    @(posedge clk_i); #1;
    model[REG_DL] = 8'h5C;
    chk("R7 new value after edge", {8'h0, rd_a_data_o}, 16'h005C);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic t_pairs();
    logic [15:0] v [4] = '{16'h1234, 16'hBEEF, 16'h00FF, 16'h8001};
    for (int p = 0; p < 4; p++) begin
      wr_byte(3'(2 * p), v[p][7:0]);
      wr_byte(3'(2 * p + 1), v[p][15:8]);
    end
    for (int p = 0; p < 4; p++) begin
      pair_addr_i = 3'(2 * p); #1;
      chk("R9 pair even sel", pair_data_o, v[p]);
      pair_addr_i = 3'(2 * p + 1); #1;
      chk("R8 pair bit0 ignored", pair_data_o, v[p]);
    end
    wr_byte(REG_AH, 8'h9A);
    pair_addr_i = REG_AL; #1;
    chk("R8 high byte order", pair_data_o, 16'h9A34);
  endtask

  task automatic t_async_reset();
    @(negedge clk_i); #2;
    rst_ni = 1'b0; #1;
    for (int i = 0; i < 8; i++) begin
      rd_a_addr_i = 3'(i); pair_addr_i = 3'(i); #0.2;
      chk("R2 async clear", {8'h0, rd_a_data_o}, 16'h0);
      chk("R2 async clear pair", pair_data_o, 16'h0);
    end
    for (int i = 0; i < 8; i++) model[i] = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    wr_byte(REG_BH, 8'h77);
    rd_a_addr_i = REG_BH; #1;
    chk("R3 write after reset", {8'h0, rd_a_data_o}, 16'h0077);
  endtask

  initial begin
    #1_000_000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    #22;
    t_reset_state();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_write_all();
    t_isolation();
    t_we_low();
    t_same_cycle();
    t_pairs();
    t_async_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule